// File: doc/BRIEF.md
# Capability Manipulation Unit

This block applies one capability manipulation operation to an unpacked capability in one clock cycle. The capability holds a type code, a permission code, a cursor, and a pair of bounds (base and end). The operations are: add to the cursor (from a register or from an immediate), narrow the bounds, reduce the permissions, convert a linear capability to non-linear, promote a fully written uninitialised capability to linear, and seal a linear capability.

Each operation is guarded. An operation that fails its guard does not change the capability. Instead it raises a trap flag with a cause code. The surrounding pipeline supplies the destination capability, the integer operands and an opcode, and it writes back the capability only when no trap is reported. The result is registered, so it appears one clock after the request.

Top module: `capop_unit`

## Requirements
- R1: A request with `in_valid` high produces its result on the outputs one clock later, with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low on the next clock. While `rst_n` is low, every output is zero.
- R2: Opcode 7 is reserved and traps with cause 5, whatever `in_is_cap` is. For any other opcode, a request with `in_is_cap` low traps with cause 1. Cause 0 means no trap.
- R3: Whenever `out_trap` is high, the output type, perms, cursor, base and end equal the request's input fields. Whenever it is low, `out_cause` is 0.
- R4: Opcode 0 adds `in_opa` to the cursor modulo 2^64 and checks no bounds. Every other field is left unchanged, and an offset of zero leaves the capability unchanged.
- R5: Opcode 1 adds the 12-bit `in_imm`, sign-extended to 64 bits, to the cursor modulo 2^64.
- R6: Opcode 2 takes a new lower bound from `in_opa` and a new upper bound from `in_opb`. It traps with cause 3 if lower > upper, if lower < base, or if upper > end. Otherwise it sets base and end to the new values. Equal bounds are allowed.
- R7: Opcode 3 takes a new perms value from `in_opa`. It traps with cause 4 if `in_opa` is greater than 4 (any upper bit set counts) or if the new value is not at or below the current perms. Otherwise it replaces perms.
- R8: The perms order is as follows. Perms codes are 0 none, 1 read-only, 2 read-execute, 3 read-write and 4 read-write-execute. Every value is at or below itself. 0 is at or below every value. 1 is at or below 2, 3 and 4. 2 and 3 are each at or below 4. 2 and 3 are not comparable.
- R9: Opcode 4 traps with cause 2 unless the type is 0 (linear). Otherwise it sets the type to 1 (non-linear).
- R10: Opcode 5 traps with cause 2 unless the type is 3 (uninitialised). It then traps with cause 6 if the cursor differs from end. Otherwise it sets the type to 0.
- R11: Opcode 6 traps with cause 2 unless the type is 0. Otherwise it sets the type to 4 (sealed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 3 | Operation code |
| in_is_cap | input | 1 | Destination operand holds a capability |
| in_type | input | 3 | Capability type code |
| in_perms | input | 3 | Capability permission code |
| in_cursor | input | 64 | Capability cursor |
| in_base | input | 64 | Capability lower bound |
| in_end | input | 64 | Capability upper bound |
| in_opa | input | 64 | First integer operand (offset, new lower bound, new perms) |
| in_opb | input | 64 | Second integer operand (new upper bound) |
| in_imm | input | 12 | Immediate offset |
| out_valid | output | 1 | Result present |
| out_trap | output | 1 | Operation refused |
| out_cause | output | 3 | Trap cause code |
| out_type | output | 3 | Resulting type |
| out_perms | output | 3 | Resulting perms |
| out_cursor | output | 64 | Resulting cursor |
| out_base | output | 64 | Resulting lower bound |
| out_end | output | 64 | Resulting upper bound |

## Verification
Cursor addition is driven with small positive offsets, a zero offset, and an offset that carries past 2^64. The immediate form is driven with -1, the most positive immediate and the most negative immediate, which separates sign extension from zero extension.

Shrink is driven with each of its three failing comparisons on its own, with bounds equal to the old bounds, and with an empty range. Tighten walks several pairs of the perms order, including the two incomparable values and an operand whose only fault is an upper bit.

The type-changing operations are each driven once with an accepted type and once with a rejected type. Initialise is also driven with the right type but a cursor one byte short of end. Non-capability inputs and the reserved opcode confirm the precedence of the trap causes.

// File: rtl/capop_pkg.sv
package capop_pkg;

    localparam int CAP_AW  = 64;
    localparam int TYPE_W  = 3;
    localparam int PERM_W  = 3;
    localparam int CAUSE_W = 3;
    localparam int OP_W    = 3;
    localparam int PERM_MAX = 4;

    typedef enum logic [OP_W-1:0] {
        OP_INC_REG = 3'd0,
        OP_INC_IMM = 3'd1,
        OP_SHRINK  = 3'd2,
        OP_TIGHTEN = 3'd3,
        OP_DELIN   = 3'd4,
        OP_INIT    = 3'd5,
        OP_SEAL    = 3'd6,
        OP_RSVD    = 3'd7
    } op_e;

    typedef enum logic [CAUSE_W-1:0] {
        CS_NONE     = 3'd0,
        CS_NOT_CAP  = 3'd1,
        CS_TYPE     = 3'd2,
        CS_BOUNDS   = 3'd3,
        CS_PERM     = 3'd4,
        CS_BAD_OP   = 3'd5,
        CS_NOT_FULL = 3'd6
    } cause_e;

    localparam logic [TYPE_W-1:0] TY_LINEAR  = 3'd0;
    localparam logic [TYPE_W-1:0] TY_NONLIN  = 3'd1;
    localparam logic [TYPE_W-1:0] TY_UNINIT  = 3'd3;
    localparam logic [TYPE_W-1:0] TY_SEALED  = 3'd4;

    typedef struct packed {
        logic [TYPE_W-1:0] ctype;
        logic [PERM_W-1:0] perms;
        logic [CAP_AW-1:0] cursor;
        logic [CAP_AW-1:0] base;
        logic [CAP_AW-1:0] lim;
    } cap_t;

    typedef struct packed {
        logic   valid;
        logic   trap;
        cause_e cause;
        cap_t   cap;
    } stage_t;

    // True when permission a sits at or below permission b in the partial order.
    function automatic logic perm_le(input logic [PERM_W-1:0] a, input logic [PERM_W-1:0] b);
        logic r;
        r = (a == b) || (a == 3'd0);
        if (a == 3'd1 && (b == 3'd2 || b == 3'd3 || b == 3'd4)) r = 1'b1;
        if ((a == 3'd2 || a == 3'd3) && b == 3'd4) r = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/capop_cursor.sv
module capop_cursor #(
    parameter int AW    = 64,
    parameter int IMM_W = 12
) (
    input  logic             use_imm,
    input  logic [AW-1:0]    cursor,
    input  logic [AW-1:0]    reg_off,
    input  logic [IMM_W-1:0] imm,
    output logic [AW-1:0]    sum
);
    localparam int EXT_W = AW - IMM_W;

    logic [AW-1:0] imm_ext;
    logic [AW-1:0] offset;

    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        offset  = use_imm ? imm_ext : reg_off;
        sum     = cursor + offset;
    end
endmodule

// File: rtl/capop_guard.sv
module capop_guard
    import capop_pkg::*;
#(
    parameter int AW = 64
) (
    input  op_e           op,
    input  logic          is_cap,
    input  cap_t          cap,
    input  logic [AW-1:0] opa,
    input  logic [AW-1:0] opb,
    output logic          trap,
    output cause_e        cause
);
    logic lo_above_hi;
    logic lo_below_base;
    logic hi_above_lim;
    logic perm_range_bad;
    logic perm_order_bad;

    always_comb begin
        lo_above_hi    = opa > opb;
        lo_below_base  = opa < cap.base;
        hi_above_lim   = opb > cap.lim;
        perm_range_bad = opa > AW'(PERM_MAX);
        perm_order_bad = !perm_le(opa[PERM_W-1:0], cap.perms);

        cause = CS_NONE;
        if (op == OP_RSVD) begin
            cause = CS_BAD_OP;
        end else if (!is_cap) begin
            cause = CS_NOT_CAP;
        end else begin
            unique case (op)
                OP_SHRINK: begin
                    if (lo_above_hi || lo_below_base || hi_above_lim) cause = CS_BOUNDS;
                end
                OP_TIGHTEN: begin
                    if (perm_range_bad || perm_order_bad) cause = CS_PERM;
                end
                OP_DELIN, OP_SEAL: begin
                    if (cap.ctype != TY_LINEAR) cause = CS_TYPE;
                end
                OP_INIT: begin
                    if (cap.ctype != TY_UNINIT)      cause = CS_TYPE;
                    else if (cap.cursor != cap.lim)  cause = CS_NOT_FULL;
                end
                default: cause = CS_NONE;
            endcase
        end
        trap = (cause != CS_NONE);
    end
endmodule

// File: rtl/capop_apply.sv
module capop_apply
    import capop_pkg::*;
#(
    parameter int AW = 64
) (
    input  op_e               op,
    input  cap_t              cap,
    input  logic [AW-1:0]     new_lo,
    input  logic [AW-1:0]     new_hi,
    input  logic [PERM_W-1:0] new_perm,
    input  logic [AW-1:0]     cursor_sum,
    output cap_t              res
);
    always_comb begin
        res = cap;
        unique case (op)
            OP_INC_REG, OP_INC_IMM: res.cursor = cursor_sum;
            OP_SHRINK: begin
                res.base = new_lo;
                res.lim  = new_hi;
            end
            OP_TIGHTEN: res.perms = new_perm;
            OP_DELIN:   res.ctype = TY_NONLIN;
            OP_INIT:    res.ctype = TY_LINEAR;
            OP_SEAL:    res.ctype = TY_SEALED;
            default:    res = cap;
        endcase
    end
endmodule

// File: rtl/capop_unit.sv
module capop_unit
    import capop_pkg::*;
#(
    parameter int AW    = capop_pkg::CAP_AW,
    parameter int IMM_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [OP_W-1:0]    in_op,
    input  logic               in_is_cap,
    input  logic [TYPE_W-1:0]  in_type,
    input  logic [PERM_W-1:0]  in_perms,
    input  logic [AW-1:0]      in_cursor,
    input  logic [AW-1:0]      in_base,
    input  logic [AW-1:0]      in_end,
    input  logic [AW-1:0]      in_opa,
    input  logic [AW-1:0]      in_opb,
    input  logic [IMM_W-1:0]   in_imm,
    output logic               out_valid,
    output logic               out_trap,
    output logic [CAUSE_W-1:0] out_cause,
    output logic [TYPE_W-1:0]  out_type,
    output logic [PERM_W-1:0]  out_perms,
    output logic [AW-1:0]      out_cursor,
    output logic [AW-1:0]      out_base,
    output logic [AW-1:0]      out_end
);
    op_e    op;
    cap_t   cap_in;
    cap_t   cap_new;
    logic   g_trap;
    cause_e g_cause;
    logic [AW-1:0] cur_sum;
    stage_t st_d, st_q;

    assign op = op_e'(in_op);

    always_comb begin
        cap_in.ctype  = in_type;
        cap_in.perms  = in_perms;
        cap_in.cursor = in_cursor;
        cap_in.base   = in_base;
        cap_in.lim    = in_end;
    end

    capop_cursor #(.AW(AW), .IMM_W(IMM_W)) u_cursor (
        .use_imm (op == OP_INC_IMM),
        .cursor  (in_cursor),
        .reg_off (in_opa),
        .imm     (in_imm),
        .sum     (cur_sum)
    );

    capop_guard #(.AW(AW)) u_guard (
        .op     (op),
        .is_cap (in_is_cap),
        .cap    (cap_in),
        .opa    (in_opa),
        .opb    (in_opb),
        .trap   (g_trap),
        .cause  (g_cause)
    );

    capop_apply #(.AW(AW)) u_apply (
        .op         (op),
        .cap        (cap_in),
        .new_lo     (in_opa),
        .new_hi     (in_opb),
        .new_perm   (in_opa[PERM_W-1:0]),
        .cursor_sum (cur_sum),
        .res        (cap_new)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.trap  = g_trap;
            st_d.cause = g_cause;
            st_d.cap   = g_trap ? cap_in : cap_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_trap   = st_q.trap;
    assign out_cause  = st_q.cause;
    assign out_type   = st_q.cap.ctype;
    assign out_perms  = st_q.cap.perms;
    assign out_cursor = st_q.cap.cursor;
    assign out_base   = st_q.cap.base;
    assign out_end    = st_q.cap.lim;
endmodule

// File: rtl/capop_checker.sv
module capop_checker #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [2:0]    in_op,
    input logic          in_is_cap,
    input logic [2:0]    in_type,
    input logic [2:0]    in_perms,
    input logic [AW-1:0] in_cursor,
    input logic [AW-1:0] in_base,
    input logic [AW-1:0] in_end,
    input logic [AW-1:0] in_opa,
    input logic          out_valid,
    input logic          out_trap,
    input logic [2:0]    out_cause,
    input logic [2:0]    out_type,
    input logic [2:0]    out_perms,
    input logic [AW-1:0] out_cursor,
    input logic [AW-1:0] out_base,
    input logic [AW-1:0] out_end
);
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_bad_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd7) |=> (out_trap && out_cause == 3'd5));

    p_not_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != 3'd7 && !in_is_cap) |=> (out_trap && out_cause == 3'd1));

    p_hold_on_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_trap || (out_type == $past(in_type) && out_perms == $past(in_perms)
            && out_cursor == $past(in_cursor) && out_base == $past(in_base)
            && out_end == $past(in_end))));

    p_cause_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_trap == (out_cause != 3'd0)));

    p_incr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_cap && in_op == 3'd0) |=>
            (!out_trap && out_cursor == $past(in_cursor + in_opa) && out_base == $past(in_base)));

    p_shrink_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd2) |=> (out_trap || (out_base <= out_end)));

    p_tighten_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd3) |=> (out_trap || out_perms <= 3'd4));

    p_delin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_cap && in_op == 3'd4 && in_type == 3'd0) |=> (!out_trap && out_type == 3'd1));

    p_seal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_cap && in_op == 3'd6 && in_type == 3'd0) |=> (!out_trap && out_type == 3'd4));
endmodule

bind capop_unit capop_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_is_cap  (in_is_cap),
    .in_type    (in_type),
    .in_perms   (in_perms),
    .in_cursor  (in_cursor),
    .in_base    (in_base),
    .in_end     (in_end),
    .in_opa     (in_opa),
    .out_valid  (out_valid),
    .out_trap   (out_trap),
    .out_cause  (out_cause),
    .out_type   (out_type),
    .out_perms  (out_perms),
    .out_cursor (out_cursor),
    .out_base   (out_base),
    .out_end    (out_end)
);

// File: tb/tb_capop_unit.sv
module tb_capop_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic        in_is_cap = 1'b0;
    logic [2:0]  in_type = '0;
    logic [2:0]  in_perms = '0;
    logic [63:0] in_cursor = '0, in_base = '0, in_end = '0, in_opa = '0, in_opb = '0;
    logic [11:0] in_imm = '0;
    logic        out_valid, out_trap;
    logic [2:0]  out_cause, out_type, out_perms;
    logic [63:0] out_cursor, out_base, out_end;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    capop_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_is_cap(in_is_cap),
        .in_type(in_type), .in_perms(in_perms), .in_cursor(in_cursor), .in_base(in_base),
        .in_end(in_end), .in_opa(in_opa), .in_opb(in_opb), .in_imm(in_imm),
        .out_valid(out_valid), .out_trap(out_trap), .out_cause(out_cause), .out_type(out_type),
        .out_perms(out_perms), .out_cursor(out_cursor), .out_base(out_base), .out_end(out_end)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic        iscap;
        logic [2:0]  typ;
        logic [2:0]  prm;
        logic [63:0] cur;
        logic [63:0] bas;
        logic [63:0] lim;
        logic [63:0] a;
        logic [63:0] b;
        logic [11:0] imm;
        logic        etrap;
        logic [2:0]  ecause;
        logic [2:0]  etyp;
        logic [2:0]  eprm;
        logic [63:0] ecur;
        logic [63:0] ebas;
        logic [63:0] elim;
        logic [3:0]  req;
    } vec_t;

    localparam logic [63:0] B = 64'h1000;
    localparam logic [63:0] E = 64'h2000;
    localparam logic [63:0] C = 64'h1800;
    localparam int NV = 31;

    localparam vec_t VECS [NV] = '{
        // R4 register offset, wrap, zero
        '{3'd0, 1'b1, 3'd0, 3'd4, C, B, E, 64'h10, 64'h0, 12'h0, 1'b0, 3'd0, 3'd0, 3'd4, 64'h1810, B, E, 4'd4},
        '{3'd0, 1'b1, 3'd0, 3'd4, 64'hFFFF_FFFF_FFFF_FFF0, B, E, 64'h20, 64'h0, 12'h0, 1'b0, 3'd0, 3'd0, 3'd4, 64'h10, B, E, 4'd4},
        '{3'd0, 1'b1, 3'd1, 3'd3, C, B, E, 64'h0, 64'h0, 12'h0, 1'b0, 3'd0, 3'd1, 3'd3, C, B, E, 4'd4},
        // R5 immediate: -1, max positive, most negative
        '{3'd1, 1'b1, 3'd0, 3'd4, C, B, E, 64'h0, 64'h0, 12'hFFF, 1'b0, 3'd0, 3'd0, 3'd4, 64'h17FF, B, E, 4'd5},
        '{3'd1, 1'b1, 3'd0, 3'd4, C, B, E, 64'h0, 64'h0, 12'h7FF, 1'b0, 3'd0, 3'd0, 3'd4, 64'h1FFF, B, E, 4'd5},
        '{3'd1, 1'b1, 3'd0, 3'd4, C, B, E, 64'h0, 64'h0, 12'h800, 1'b0, 3'd0, 3'd0, 3'd4, 64'h1000, B, E, 4'd5},
        // R6 shrink
        '{3'd2, 1'b1, 3'd0, 3'd4, C, B, E, 64'h1100, 64'h1F00, 12'h0, 1'b0, 3'd0, 3'd0, 3'd4, C, 64'h1100, 64'h1F00, 4'd6},
        '{3'd2, 1'b1, 3'd0, 3'd4, C, B, E, 64'h1800, 64'h1700, 12'h0, 1'b1, 3'd3, 3'd0, 3'd4, C, B, E, 4'd6},
        '{3'd2, 1'b1, 3'd0, 3'd4, C, B, E, 64'h0FFF, 64'h1800, 12'h0, 1'b1, 3'd3, 3'd0, 3'd4, C, B, E, 4'd6},
        '{3'd2, 1'b1, 3'd0, 3'd4, C, B, E, 64'h1000, 64'h2001, 12'h0, 1'b1, 3'd3, 3'd0, 3'd4, C, B, E, 4'd6},
        '{3'd2, 1'b1, 3'd0, 3'd4, C, B, E, B, E, 12'h0, 1'b0, 3'd0, 3'd0, 3'd4, C, B, E, 4'd6},
        '{3'd2, 1'b1, 3'd0, 3'd4, C, B, E, 64'h1500, 64'h1500, 12'h0, 1'b0, 3'd0, 3'd0, 3'd4, C, 64'h1500, 64'h1500, 4'd6},
        // R7 / R8 tighten
        '{3'd3, 1'b1, 3'd0, 3'd4, C, B, E, 64'd3, 64'h0, 12'h0, 1'b0, 3'd0, 3'd0, 3'd3, C, B, E, 4'd7},
        '{3'd3, 1'b1, 3'd0, 3'd3, C, B, E, 64'd2, 64'h0, 12'h0, 1'b1, 3'd4, 3'd0, 3'd3, C, B, E, 4'd8},
        '{3'd3, 1'b1, 3'd0, 3'd2, C, B, E, 64'd3, 64'h0, 12'h0, 1'b1, 3'd4, 3'd0, 3'd2, C, B, E, 4'd8},
        '{3'd3, 1'b1, 3'd0, 3'd2, C, B, E, 64'd2, 64'h0, 12'h0, 1'b0, 3'd0, 3'd0, 3'd2, C, B, E, 4'd8},
        '{3'd3, 1'b1, 3'd0, 3'd2, C, B, E, 64'd1, 64'h0, 12'h0, 1'b0, 3'd0, 3'd0, 3'd1, C, B, E, 4'd8},
        '{3'd3, 1'b1, 3'd0, 3'd1, C, B, E, 64'd0, 64'h0, 12'h0, 1'b0, 3'd0, 3'd0, 3'd0, C, B, E, 4'd8},
        '{3'd3, 1'b1, 3'd0, 3'd4, C, B, E, 64'd5, 64'h0, 12'h0, 1'b1, 3'd4, 3'd0, 3'd4, C, B, E, 4'd7},
        '{3'd3, 1'b1, 3'd0, 3'd4, C, B, E, 64'h1_0000_0003, 64'h0, 12'h0, 1'b1, 3'd4, 3'd0, 3'd4, C, B, E, 4'd7},
        // R9 delinearise
        '{3'd4, 1'b1, 3'd0, 3'd4, C, B, E, 64'h0, 64'h0, 12'h0, 1'b0, 3'd0, 3'd1, 3'd4, C, B, E, 4'd9},
        '{3'd4, 1'b1, 3'd1, 3'd4, C, B, E, 64'h0, 64'h0, 12'h0, 1'b1, 3'd2, 3'd1, 3'd4, C, B, E, 4'd9},
        // R10 initialise
        '{3'd5, 1'b1, 3'd3, 3'd3, E, B, E, 64'h0, 64'h0, 12'h0, 1'b0, 3'd0, 3'd0, 3'd3, E, B, E, 4'd10},
        '{3'd5, 1'b1, 3'd3, 3'd3, 64'h1FFF, B, E, 64'h0, 64'h0, 12'h0, 1'b1, 3'd6, 3'd3, 3'd3, 64'h1FFF, B, E, 4'd10},
        '{3'd5, 1'b1, 3'd0, 3'd3, E, B, E, 64'h0, 64'h0, 12'h0, 1'b1, 3'd2, 3'd0, 3'd3, E, B, E, 4'd10},
        // R11 seal
        '{3'd6, 1'b1, 3'd0, 3'd4, C, B, E, 64'h0, 64'h0, 12'h0, 1'b0, 3'd0, 3'd4, 3'd4, C, B, E, 4'd11},
        '{3'd6, 1'b1, 3'd4, 3'd4, C, B, E, 64'h0, 64'h0, 12'h0, 1'b1, 3'd2, 3'd4, 3'd4, C, B, E, 4'd11},
        // R2 non-capability and reserved opcode
        '{3'd4, 1'b0, 3'd0, 3'd4, C, B, E, 64'h0, 64'h0, 12'h0, 1'b1, 3'd1, 3'd0, 3'd4, C, B, E, 4'd2},
        '{3'd0, 1'b0, 3'd0, 3'd4, C, B, E, 64'h10, 64'h0, 12'h0, 1'b1, 3'd1, 3'd0, 3'd4, C, B, E, 4'd2},
        '{3'd7, 1'b1, 3'd0, 3'd4, C, B, E, 64'h0, 64'h0, 12'h0, 1'b1, 3'd5, 3'd0, 3'd4, C, B, E, 4'd2},
        '{3'd7, 1'b0, 3'd0, 3'd4, C, B, E, 64'h0, 64'h0, 12'h0, 1'b1, 3'd5, 3'd0, 3'd4, C, B, E, 4'd2}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid = 1'b1; in_op = v.op; in_is_cap = v.iscap; in_type = v.typ; in_perms = v.prm;
        in_cursor = v.cur; in_base = v.bas; in_end = v.lim; in_opa = v.a; in_opb = v.b; in_imm = v.imm;
    endtask

    // Called at a negedge: drive, wait one clock, check at the next negedge.
    task automatic run_vec(input int idx, input vec_t v);
        string t;
        string ft;
        drive(v);
        @(negedge clk);
        t  = $sformatf("R%0d vec%0d", v.req, idx);
        ft = v.etrap ? $sformatf("R3 vec%0d", idx) : t;
        chk(out_valid == 1'b1, $sformatf("R1 vec%0d valid", idx), 64'(out_valid), 64'd1);
        chk(out_trap == v.etrap, {t, " trap"}, 64'(out_trap), 64'(v.etrap));
        chk(out_cause == v.ecause, {t, " cause"}, 64'(out_cause), 64'(v.ecause));
        chk(out_type == v.etyp, {ft, " type"}, 64'(out_type), 64'(v.etyp));
        chk(out_perms == v.eprm, {ft, " perms"}, 64'(out_perms), 64'(v.eprm));
        chk(out_cursor == v.ecur, {ft, " cursor"}, out_cursor, v.ecur);
        chk(out_base == v.ebas, {ft, " base"}, out_base, v.ebas);
        chk(out_end == v.elim, {ft, " end"}, out_end, v.elim);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs are zero while reset is held
        chk(out_valid == 1'b0 && out_trap == 1'b0 && out_cause == 3'd0, "R1 reset flags",
            64'({out_valid, out_trap, out_cause}), 64'd0);
        chk(out_cursor == 64'd0 && out_base == 64'd0 && out_end == 64'd0, "R1 reset fields",
            out_cursor | out_base | out_end, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

        // R1: idle cycle drops out_valid one clock later
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle valid", 64'(out_valid), 64'd0);

        // R3: a trapped request back to back with an accepted one keeps its own inputs
        run_vec(100, VECS[21]);
        run_vec(101, VECS[20]);

        // R1: reset during activity clears the outputs at once
        drive(VECS[0]);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(out_valid == 1'b0 && out_cursor == 64'd0, "R1 mid-run reset",
            out_cursor, 64'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        finish_run();
    end
endmodule